// File: doc/BRIEF.md
# Successive-approximation converter sequencer

This block is the digital half of an 8-bit successive-approximation analog-to-digital converter that sits on a host bus as a memory or I/O location. The host starts a conversion with an active-low strobe qualified by an active-low select. The host reads the result through a tri-state data port, enabled by an active-low read strobe under the same select. An active-low interrupt tells the host that a fresh result is waiting.

On the analog side the block presents a trial code to an external ladder DAC and receives a single comparator bit back. A 1 means the input is at or above the trial code. The search runs on internal phases at one eighth of the block clock, so each bit decision takes eight clocks. A wide start strobe holds the search in reset, and the search only begins once the strobe is released. Restarting mid-search abandons the old search and leaves the previous result in place.

Top module: `sar_seq_top`

## Requirements
- R1: A synchronous active-high `rst` sets `intrN` high, clears the result latch to 0x00 and sets `trialCode` to 0x00.
- R2: While `csN` and `wrN` are both low, the search is held in reset. From the next clock on, `trialCode` reads 0x00 and `intrN` is high, and no conversion completes for as long as the hold lasts.
- R3: After the start strobe is released, counting the first clock edge at which it is seen released as edge 1, `intrN` goes low after edge 66 at the earliest and after edge 73 at the latest. This is a 1 to 8 clock alignment wait, then 64 clocks of search, then one clock from the latch update to the interrupt.
- R4: The search decides bits from the most significant down. A comparator 1 keeps the trial bit and a 0 clears it, so an ideal comparator yields the input code itself. A full-scale input gives 0xFF and a zero input gives 0x00.
- R5: `trialCode` shows the candidate word with the bit under test set. Each candidate stays constant for exactly 8 clocks. For input 0xA5 the candidates are 0x80, 0xC0, 0xA0, 0xB0, 0xA8, 0xA4, 0xA6, 0xA5 in that order.
- R6: While `csN` and `rdN` are both low, `dataOut` drives the result latch; otherwise it is high impedance. The latch takes the new word when the search completes.
- R7: A read (`csN` and `rdN` low at a clock edge) clears `intrN` to high at that edge. A read during the 8 clocks after `intrN` falls has no effect, and a read 8 or more clocks after the fall clears it.
- R8: With `csN` and `rdN` held low throughout, `intrN` still falls at end of conversion and stays low for exactly 8 clocks.
- R9: A new start during a search abandons it and begins a fresh search. The result latch keeps the previous word and `intrN` stays high until the fresh search completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; internal phases run at one eighth of it |
| rst | input | 1 | Synchronous active-high reset |
| csN | input | 1 | Active-low select qualifying start and read |
| wrN | input | 1 | Active-low start strobe |
| rdN | input | 1 | Active-low read strobe (output enable) |
| cmpIn | input | 1 | Comparator result: 1 when the input is at or above `trialCode` |
| trialCode | output | 8 | Candidate code driving the external ladder DAC |
| dataOut | output | 8 | Tri-state result port |
| intrN | output | 1 | Active-low end-of-conversion interrupt |

## Verification
The assertions check the following on every cycle:
- a start hold forces the interrupt high and the trial code to zero on the next clock;
- the trial code never changes on two consecutive clocks outside a hold;
- a falling interrupt stays low for at least one more clock;
- reset leaves the interrupt high.

Only the bench's scenarios can show the rest, because each needs a known analog input and a count across many clocks:
- the conversion results and the start-to-interrupt window;
- the exact candidate order and the 8-clock slot width;
- the 8-clock read lockout and the continuous-read pulse width;
- that an abandoned search keeps the old result.

// File: rtl/sar_seq_pkg.sv
`timescale 1ns/1ps
package sar_seq_pkg;
  parameter int unsigned CODE_W = 8;              // result width
  parameter int unsigned DIV_W  = 3;              // phase divider is 2**DIV_W clocks
  localparam int unsigned IDX_W = $clog2(CODE_W);
  localparam int unsigned SET_W = DIV_W + 1;      // holds 2**DIV_W
  localparam int unsigned SLOT  = 1 << DIV_W;

  typedef struct packed {
    logic             clear;   // start hold: wipe search
    logic             seed;    // load MSB candidate
    logic             decide;  // resolve current bit from comparator
    logic [IDX_W-1:0] bitSel;  // bit under test
    logic             finish;  // last decision: capture result
  } sarStrobe_t;
endpackage

// File: rtl/sar_seq_ctrl.sv
`timescale 1ns/1ps
module sar_seq_ctrl
  import sar_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       startHold,
  input  logic       readSel,
  output sarStrobe_t strobe,
  output logic       intrFlag
);
  logic [DIV_W-1:0] phase;
  logic             startPend;
  logic             busy;
  logic [IDX_W-1:0] bitIdx;
  logic [SET_W-1:0] setCnt;
  logic             slotEnd;

  assign slotEnd = &phase;

  always_comb begin
    strobe.clear  = startHold;
    strobe.seed   = !startHold && startPend && slotEnd;
    strobe.decide = !startHold && busy && slotEnd;
    strobe.bitSel = bitIdx;
    strobe.finish = strobe.decide && (bitIdx == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= '0;
      startPend <= 1'b0;
      busy      <= 1'b0;
      bitIdx    <= '0;
      setCnt    <= '0;
      intrFlag  <= 1'b0;
    end else begin
      phase <= phase + 1'b1;
      if (startHold) begin
        startPend <= 1'b1;
        busy      <= 1'b0;
        setCnt    <= '0;
        intrFlag  <= 1'b0;
      end else begin
        // interrupt: set window dominates any read
        if (setCnt != '0) begin
          setCnt   <= setCnt - 1'b1;
          intrFlag <= 1'b1;
        end else if (readSel) begin
          intrFlag <= 1'b0;
        end
        if (strobe.seed) begin
          startPend <= 1'b0;
          busy      <= 1'b1;
          bitIdx    <= IDX_W'(CODE_W - 1);
        end else if (strobe.decide) begin
          if (strobe.finish) begin
            busy   <= 1'b0;
            setCnt <= SET_W'(SLOT);
          end else begin
            bitIdx <= bitIdx - 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sar_seq_dp.sv
`timescale 1ns/1ps
module sar_seq_dp
  import sar_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  sarStrobe_t        strobe,
  input  logic              cmpIn,
  input  logic              readSel,
  output logic [CODE_W-1:0] trialCode,
  output logic [CODE_W-1:0] dataOut
);
  logic [CODE_W-1:0] sarReg;
  logic [CODE_W-1:0] resultReg;
  logic [CODE_W-1:0] decided;

  // per bit: resolve the tested bit, raise the next lower candidate bit
  for (genvar b = 0; b < CODE_W; b++) begin : g_bit
    if (b == CODE_W - 1) begin : g_top
      assign decided[b] = (strobe.bitSel == IDX_W'(b)) ? cmpIn : sarReg[b];
    end else begin : g_low
      assign decided[b] = (strobe.bitSel == IDX_W'(b))     ? cmpIn :
                          (strobe.bitSel == IDX_W'(b + 1)) ? 1'b1  : sarReg[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.clear) begin
      sarReg <= '0;
    end else if (strobe.seed) begin
      sarReg <= {1'b1, {(CODE_W-1){1'b0}}};
    end else if (strobe.decide) begin
      sarReg <= decided;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resultReg <= '0;
    end else if (strobe.finish) begin
      resultReg <= decided;
    end
  end

  assign trialCode = sarReg;
  assign dataOut   = readSel ? resultReg : {CODE_W{1'bz}};
endmodule

// File: rtl/sar_seq_top.sv
`timescale 1ns/1ps
module sar_seq_top
  import sar_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              csN,
  input  logic              wrN,
  input  logic              rdN,
  input  logic              cmpIn,
  output logic [CODE_W-1:0] trialCode,
  output logic [CODE_W-1:0] dataOut,
  output logic              intrN
);
  sarStrobe_t strobe;
  logic       intrFlag;
  logic       startHold;
  logic       readSel;

  assign startHold = !csN && !wrN;
  assign readSel   = !csN && !rdN;
  assign intrN     = !intrFlag;

  sar_seq_ctrl ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .startHold (startHold),
    .readSel   (readSel),
    .strobe    (strobe),
    .intrFlag  (intrFlag)
  );

  sar_seq_dp dp_i (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .cmpIn     (cmpIn),
    .readSel   (readSel),
    .trialCode (trialCode),
    .dataOut   (dataOut)
  );
endmodule

// File: rtl/sar_seq_chk.sv
`timescale 1ns/1ps
module sar_seq_chk
  import sar_seq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              csN,
  input logic              wrN,
  input logic [CODE_W-1:0] trialCode,
  input logic              intrN
);
  AST_RESET_INTR_HIGH: assert property (@(posedge clk) rst |=> intrN); // R1

  AST_HOLD_CLEARS_INTR: assert property (@(posedge clk) disable iff (rst)
    (!csN && !wrN) |=> intrN); // R2

  AST_HOLD_CLEARS_TRIAL: assert property (@(posedge clk) disable iff (rst)
    (!csN && !wrN) |=> (trialCode == '0)); // R2

  AST_TRIAL_SLOT_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!$stable(trialCode) && (csN || wrN) && !$past(!csN && !wrN)) |=> $stable(trialCode)); // R5

  AST_INTR_MIN_WIDTH: assert property (@(posedge clk) disable iff (rst)
    ($fell(intrN) && (csN || wrN)) |=> !intrN); // R8
endmodule

bind sar_seq_top sar_seq_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .csN       (csN),
  .wrN       (wrN),
  .trialCode (trialCode),
  .intrN     (intrN)
);

// File: tb/sar_seq_top_tb_top.sv
`timescale 1ns/1ps
module sar_seq_top_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1;
  logic csN = 1'b1;
  logic wrN = 1'b1;
  logic rdN = 1'b1;
  logic [7:0] vin = 8'h00;
  logic [7:0] trialCode;
  logic [7:0] dataOut;
  logic intrN;
  logic cmpIn;

  assign cmpIn = (trialCode <= vin);   // ideal comparator

  int nChk = 0;
  int nBad = 0;

  sar_seq_top dut_i (
    .clk(clk), .rst(rst), .csN(csN), .wrN(wrN), .rdN(rdN),
    .cmpIn(cmpIn), .trialCode(trialCode), .dataOut(dataOut), .intrN(intrN)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  task automatic startPulse(input int width);
    @(negedge clk); csN = 1'b0; wrN = 1'b0;
    repeat (width) @(negedge clk);
    wrN = 1'b1; csN = 1'b1;
  endtask

  // counts edges from release until intrN seen low
  task automatic waitIntr(output int k);
    k = 0;
    do begin @(negedge clk); k++; end while (intrN && k < 200);
  endtask

  task automatic checkWindow(input string tag, input int k);
    nChk++;
    if (k < 66 || k > 73) begin
      nBad++;
      $display("FAIL %s: actual %0d edges expected 66..73", tag, k);
    end
  endtask

  // called at the negedge where intrN was first seen low
  task automatic clearLate();
    repeat (7) @(negedge clk);
    csN = 1'b0; rdN = 1'b0;
    @(negedge clk); csN = 1'b1; rdN = 1'b1;
    check("R7 late read clears", intrN, 1'b1);
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 intrN after reset", intrN, 1'b1);
    check("R1 trialCode after reset", trialCode, 8'h00);
    csN = 1'b0; rdN = 1'b0; #1;
    check("R1 R6 latch after reset", dataOut, 8'h00);
    @(negedge clk); csN = 1'b1; rdN = 1'b1;
  endtask

  task automatic t_convert(input logic [7:0] code);
    int k;
    vin = code;
    startPulse(1);
    waitIntr(k);
    checkWindow("R3 start to interrupt", k);
    csN = 1'b0; rdN = 1'b0; #1;
    check("R4 R6 result", dataOut, {24'h0, code});
    @(negedge clk); csN = 1'b1; rdN = 1'b1;
    check("R7 early read ignored", intrN, 1'b0);
    repeat (6) @(negedge clk);
    csN = 1'b0; rdN = 1'b0;
    @(negedge clk); csN = 1'b1; rdN = 1'b1;
    check("R7 read after 8 clocks clears", intrN, 1'b1);
  endtask

  task automatic t_trial();
    logic [7:0] expSeq [8] = '{8'h80, 8'hC0, 8'hA0, 8'hB0, 8'hA8, 8'hA4, 8'hA6, 8'hA5};
    logic [7:0] seen [8];
    int dur [8];
    int n = 0;
    int guard = 0;
    logic [7:0] prev;
    vin = 8'hA5;
    startPulse(1);
    prev = trialCode;
    check("R2 trial cleared by hold", trialCode, 8'h00);
    while (intrN && guard < 200) begin
      @(negedge clk); guard++;
      if (trialCode != prev) begin
        if (n < 8) begin seen[n] = trialCode; dur[n] = 1; end
        n++;
        prev = trialCode;
      end else if (n > 0 && n <= 8) begin
        dur[n-1]++;
      end
    end
    check("R5 candidate count", n, 8);
    for (int i = 0; i < 8; i++) begin
      if (i < n) check("R5 candidate order", seen[i], expSeq[i]);
      if (i < 7 && i < n) check("R5 slot width", dur[i], 8);
    end
    clearLate();
  endtask

  task automatic t_hold();
    int k;
    vin = 8'h96;
    startPulse(1);
    waitIntr(k);
    csN = 1'b0; wrN = 1'b0;
    @(negedge clk);
    check("R2 hold raises intrN", intrN, 1'b1);
    check("R2 hold clears trial", trialCode, 8'h00);
    repeat (100) @(negedge clk);
    check("R2 no completion during hold", intrN, 1'b1);
    check("R2 trial zero during hold", trialCode, 8'h00);
    wrN = 1'b1; csN = 1'b1;
    waitIntr(k);
    checkWindow("R3 window after wide strobe", k);
    csN = 1'b0; rdN = 1'b0; #1;
    check("R4 result after wide strobe", dataOut, 8'h96);
    @(negedge clk); csN = 1'b1; rdN = 1'b1;
    repeat (6) @(negedge clk);
    csN = 1'b0; rdN = 1'b0;
    @(negedge clk); csN = 1'b1; rdN = 1'b1;
    check("R7 clear after wide strobe run", intrN, 1'b1);
  endtask

  task automatic t_readHeld();
    int k;
    int lowCnt = 0;
    vin = 8'h3C;
    @(negedge clk); csN = 1'b0; rdN = 1'b0; wrN = 1'b0;
    @(negedge clk); wrN = 1'b1;
    waitIntr(k);
    checkWindow("R3 window with read held", k);
    #1 check("R6 data while read held", dataOut, 8'h3C);
    while (!intrN && lowCnt < 50) begin lowCnt++; @(negedge clk); end
    check("R8 pulse width with read held", lowCnt, 8);
    csN = 1'b1; rdN = 1'b1;
  endtask

  task automatic t_restart();
    int k;
    t_convert(8'h33);
    vin = 8'hCC;
    startPulse(1);
    repeat (30) @(negedge clk);
    check("R9 intrN high mid search", intrN, 1'b1);
    vin = 8'h11;
    startPulse(1);
    repeat (20) @(negedge clk);
    check("R9 intrN high after restart", intrN, 1'b1);
    csN = 1'b0; rdN = 1'b0; #1;
    check("R9 old result kept", dataOut, 8'h33);
    @(negedge clk); csN = 1'b1; rdN = 1'b1;
    waitIntr(k);
    check("R9 new search completes", intrN, 1'b0);
    csN = 1'b0; rdN = 1'b0; #1;
    check("R9 R4 new result", dataOut, 8'h11);
    @(negedge clk); csN = 1'b1; rdN = 1'b1;
    repeat (6) @(negedge clk);
    csN = 1'b0; rdN = 1'b0;
    @(negedge clk); csN = 1'b1; rdN = 1'b1;
    check("R7 clear after restart", intrN, 1'b1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual hung expected finished");
    finishRun();
  end

  initial begin : main
    t_reset();
    t_convert(8'hFF);   // R4 full scale
    t_convert(8'h00);   // R4 zero
    t_convert(8'h5A);
    t_convert(8'h80);
    t_convert(8'h7F);
    t_convert(8'h01);
    t_trial();
    t_hold();
    t_readHeld();
    t_restart();
    finishRun();
  end
endmodule